// File: doc/BRIEF.md
# Watchdog Timer with Tick Divider

This peripheral sits on an APB bus and watches over system software. A divider turns the bus clock into evenly spaced ticks. A 24-bit count is loaded by software. While the timer is enabled and not paused, the count falls by two on each tick. The block raises a one-cycle reset request in either of two cases: the count sits at zero while the timer is enabled and not paused, or software writes the trigger bit. Three status inputs can hold the count: core-0 debug halt, core-1 debug halt and JTAG fabric access. Each one acts only while its pause-enable bit is set.

A two-bit cause register records whether the most recent request came from a timeout or from a forced trigger. Eight scratch words let software leave notes across a watchdog-initiated restart. The `soft_rst` input comes from the external reset controller. It returns control, count and tick state to their reset values and leaves the cause register and the scratch words untouched. Only `rst_n` clears them.

Top module: `guard_timer`

## Requirements
- R1: After a hardware reset, control (0x00) reads 0x0700_0000 (enable 0, the three pause bits 26:24 set, count 0), tick (0x2C) reads 0x0000_0200, cause (0x08) reads 0, every scratch word reads 0, and `pready` is 1.
- R2: A write to 0x04 loads the count with `pwdata[23:0]`. The count can be read back in control bits 23:0, and the load offset itself reads 0.
- R3: While enabled and not paused, the count falls by 2 on each tick. A count of 1 goes to 0 and never wraps.
- R4: The count holds when the enable bit (control bit 30) is 0. It also holds while any pause bit is set together with its status input: bit 26 with `core1_halted`, bit 25 with `core0_halted`, bit 24 with `jtag_active`. A status input whose pause bit is clear has no effect.
- R5: When the count is 0 and the timer is enabled and not paused, `wdog_req` pulses for exactly one cycle, the enable bit clears, and cause reads 0x1 (bit 0 = timeout).
- R6: A control write with bit 31 set raises `wdog_req` for one cycle right after the access, whether or not the timer is enabled. It clears the enable bit and sets cause to 0x2 (bit 1 = forced). Bit 31 always reads 0.
- R7: If a trigger write and a timeout fall on the same cycle, only one request pulse is produced, and cause reads 0x2.
- R8: With a cycles field (tick bits 8:0) of N > 0 and tick enable (bit 9) set, one tick occurs every N clock cycles, and the running flag (bit 10) reads 1. When the cycles field is 0 or tick enable is 0, no ticks occur and running reads 0. Bits 19:11 show the cycles remaining, which equal the cycles field while the divider is stopped.
- R9: `soft_rst` returns control, count and tick registers to their R1 values and leaves the cause register and the scratch words unchanged.
- R10: Eight 32-bit read/write scratch words sit at 0x0C, 0x10, …, 0x28.
- R11: Writes to the cause register and to control bits 23:0 are ignored. A read from an unmapped offset (e.g. 0x30) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and reference clock |
| rst_n | input | 1 | Synchronous active-low hardware reset, clears everything |
| soft_rst | input | 1 | Synchronous active-high soft reset, keeps cause and scratch |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| core0_halted | input | 1 | Core 0 is in debug halt |
| core1_halted | input | 1 | Core 1 is in debug halt |
| jtag_active | input | 1 | JTAG is accessing the bus fabric |
| wdog_req | output | 1 | One-cycle reset request |

## Verification
A timer expiry and a software trigger can land on the same clock edge. The bench arranges this in three steps:
- It holds a zero count under a JTAG pause with the enable bit set, so no timeout can fire.
- It issues a trigger write.
- It drops `jtag_active` at the start of that write's access phase, so the expiry becomes due on the very edge that takes the trigger.

The collision passes if the request output shows exactly one single-cycle pulse and the cause register then reads forced, not timeout.

// File: rtl/guard_pkg.sv
// Package: shared widths, register word indices and the cause encoding.
// Assumes word-aligned APB addresses; index = byte address / 4.
package guard_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 24;
    localparam int DIV_W     = 9;
    localparam int N_SCRATCH = 8;

    localparam int IDX_CTRL   = 0;
    localparam int IDX_LOAD   = 1;
    localparam int IDX_CAUSE  = 2;
    localparam int IDX_SCR0   = 3;
    localparam int IDX_TICK   = IDX_SCR0 + N_SCRATCH;

    localparam int BIT_TRIG   = 31;
    localparam int BIT_EN     = 30;
    localparam int BIT_PAUSE  = 24;  // 26:24 = core1, core0, jtag

    typedef struct packed {
        logic forced;
        logic timeout;
    } cause_t;
endpackage

// File: rtl/guard_tick_div.sv
// Module: guard_tick_div
// Divides the clock into single-cycle ticks, one every cfg_cycles clocks.
// Assumes: a cycles value of 0 or cfg_en low stops the divider; while
// stopped the remaining count mirrors cfg_cycles.
module guard_tick_div #(
    parameter int DIV_W = guard_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cfg_en,
    input  logic [DIV_W-1:0] cfg_cycles,
    output logic             tick,
    output logic             running,
    output logic [DIV_W-1:0] remain
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    assign running = cfg_en && (cfg_cycles != '0);
    assign tick    = running && (remain <= ONE);

    // Remaining-cycle counter: reload on tick or while stopped, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            remain <= '0;
        end else if (!running || tick) begin
            remain <= cfg_cycles;
        end else begin
            remain <= remain - ONE;
        end
    end

    assert_tick_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !soft_rst) |=> (remain == $past(cfg_cycles)));

    assert_tick_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick && !soft_rst) |=> (remain == $past(remain) - ONE));
endmodule

// File: rtl/guard_countdown.sv
// Module: guard_countdown
// 24-bit watchdog count: load has priority, then a step of -2 saturating at 0.
// Assumes: step is already qualified by enable and pause in the parent.
module guard_countdown #(
    parameter int CNT_W = guard_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             at_zero
);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    assign at_zero = (count == '0);

    // Count register: reset, load, or decrement by two with floor at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            count <= '0;
        end else if (load_stb) begin
            count <= load_val;
        end else if (step) begin
            count <= (count < TWO) ? '0 : count - TWO;
        end
    end

    assert_step_by_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_stb && !soft_rst && count >= TWO) |=> (count == $past(count) - TWO));

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_stb && !soft_rst && count < TWO) |=> (count == '0));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_stb && !soft_rst) |=> $stable(count));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !soft_rst) |=> (count == $past(load_val)));
endmodule

// File: rtl/guard_regs.sv
// Module: guard_regs
// APB register file: control, load strobe, cause, scratch words and tick
// configuration, plus the request pulse and cause capture.
// Assumes: zero-wait APB; one access phase never directly follows another.
module guard_regs
    import guard_pkg::*;
#(
    parameter int ADDR_W    = guard_pkg::ADDR_W,
    parameter int DATA_W    = guard_pkg::DATA_W,
    parameter int CNT_W     = guard_pkg::CNT_W,
    parameter int DIV_W     = guard_pkg::DIV_W,
    parameter int N_SCRATCH = guard_pkg::N_SCRATCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [DIV_W-1:0]  remain,
    input  logic              running,
    input  logic              expire,
    output logic              tmr_en,
    output logic [2:0]        pause_mask,
    output logic              div_en,
    output logic [DIV_W-1:0]  div_cycles,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic              wdog_req
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    logic              wr;
    logic              trig;
    logic              fire;
    cause_t            cause;
    logic [DATA_W-1:0] scratch [N_SCRATCH];
    logic [1:0]        unused_addr_lsb;

    assign unused_addr_lsb = paddr[1:0];
    assign idx      = paddr[ADDR_W-1:2];
    assign wr       = psel && penable && pwrite;
    assign trig     = wr && (idx == IDX_W'(IDX_CTRL)) && pwdata[BIT_TRIG];
    assign fire     = trig || expire;
    assign load_stb = wr && (idx == IDX_W'(IDX_LOAD));
    assign load_val = pwdata[CNT_W-1:0];

    // Control fields: enable and pause mask; any request clears enable.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            tmr_en     <= 1'b0;
            pause_mask <= 3'b111;
        end else begin
            if (wr && idx == IDX_W'(IDX_CTRL)) begin
                tmr_en     <= pwdata[BIT_EN];
                pause_mask <= pwdata[BIT_PAUSE+2:BIT_PAUSE];
            end
            if (fire) begin
                tmr_en <= 1'b0;
            end
        end
    end

    // Request pulse: registered copy of trigger-or-expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            wdog_req <= 1'b0;
        end else begin
            wdog_req <= fire;
        end
    end

    // Cause capture: forced wins over timeout; only hardware reset clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
        end else if (fire) begin
            cause.forced  <= trig;
            cause.timeout <= !trig;
        end
    end

    // Tick divider configuration.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            div_cycles <= '0;
            div_en     <= 1'b1;
        end else if (wr && idx == IDX_W'(IDX_TICK)) begin
            div_cycles <= pwdata[DIV_W-1:0];
            div_en     <= pwdata[DIV_W];
        end
    end

    // Scratch words: one register per word, cleared by hardware reset only.
    for (genvar i = 0; i < N_SCRATCH; i++) begin : g_scratch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                scratch[i] <= '0;
            end else if (wr && idx == IDX_W'(IDX_SCR0 + i)) begin
                scratch[i] <= pwdata;
            end
        end
    end

    // Read multiplexer; unmapped and write-only offsets return zero.
    always_comb begin
        prdata = '0;
        if (idx == IDX_W'(IDX_CTRL)) begin
            prdata[CNT_W-1:0]              = count;
            prdata[BIT_PAUSE+2:BIT_PAUSE]  = pause_mask;
            prdata[BIT_EN]                 = tmr_en;
        end else if (idx == IDX_W'(IDX_CAUSE)) begin
            prdata[1:0] = cause;
        end else if (idx == IDX_W'(IDX_TICK)) begin
            prdata[DIV_W-1:0]         = div_cycles;
            prdata[DIV_W]             = div_en;
            prdata[DIV_W+1]           = running;
            prdata[2*DIV_W+1:DIV_W+2] = remain;
        end else begin
            for (int k = 0; k < N_SCRATCH; k++) begin
                if (idx == IDX_W'(IDX_SCR0 + k)) begin
                    prdata = scratch[k];
                end
            end
        end
    end

    assert_req_clears_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_req |-> !tmr_en);

    assert_req_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_req |-> (cause != '0));

    assert_force_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !soft_rst) |=> (wdog_req && cause == 2'b10));

    assert_cause_only_on_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cause != $past(cause)) |-> wdog_req);
endmodule

// File: rtl/guard_timer.sv
// Module: guard_timer (top)
// APB watchdog: tick divider, 24-bit countdown, pause gating, request logic.
// Assumes: the tick reference is clk itself; the reset controller that
// consumes wdog_req drives soft_rst back into this block.
module guard_timer
    import guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [7:0]  paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pready,
    input  logic        core0_halted,
    input  logic        core1_halted,
    input  logic        jtag_active,
    output logic        wdog_req
);
    logic [CNT_W-1:0] count;
    logic [DIV_W-1:0] remain;
    logic [DIV_W-1:0] div_cycles;
    logic [2:0]       pause_mask;
    logic             running, tick, div_en, tmr_en, paused;
    logic             load_stb, at_zero, expire, step;
    logic [CNT_W-1:0] load_val;

    assign pready = 1'b1;
    assign paused = |(pause_mask & {core1_halted, core0_halted, jtag_active});
    assign step   = tmr_en && !paused && tick;
    assign expire = tmr_en && !paused && at_zero;

    guard_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .prdata     (prdata),
        .count      (count),
        .remain     (remain),
        .running    (running),
        .expire     (expire),
        .tmr_en     (tmr_en),
        .pause_mask (pause_mask),
        .div_en     (div_en),
        .div_cycles (div_cycles),
        .load_stb   (load_stb),
        .load_val   (load_val),
        .wdog_req   (wdog_req)
    );

    guard_tick_div u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .cfg_en     (div_en),
        .cfg_cycles (div_cycles),
        .tick       (tick),
        .running    (running),
        .remain     (remain)
    );

    guard_countdown u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .load_stb (load_stb),
        .load_val (load_val),
        .step     (step),
        .count    (count),
        .at_zero  (at_zero)
    );

    assert_paused_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !load_stb && !soft_rst) |=> $stable(count));
endmodule

// File: tb/guard_timer_bench.sv
module guard_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        core0_halted = 1'b0, core1_halted = 1'b0, jtag_active = 1'b0;
    logic        wdog_req;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic        req_prev = 1'b0;
    logic [31:0] last_rd = '0;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    guard_timer u_guard_timer (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .core0_halted(core0_halted), .core1_halted(core1_halted),
        .jtag_active(jtag_active), .wdog_req(wdog_req)
    );

    // Monitor: pops expected read data as each read access completes.
    always @(negedge clk) begin
        if (psel && penable && !pwrite && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            last_rd = prdata;
            if (it.mask != 0) begin
                checks++;
                if ((prdata & it.mask) != (it.exp & it.mask)) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h (mask %h)",
                             it.tag, prdata, it.exp, it.mask);
                end
            end
        end
    end

    // Monitor: counts request pulses and flags pulses longer than one cycle.
    always @(negedge clk) begin
        if (wdog_req && !req_prev) pulses++;
        if (wdog_req && req_prev) begin
            errors++;
            $display("FAIL R5: request high for two cycles, actual 1 expected 0");
        end
        req_prev = wdog_req;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apb_write(logic [7:0] a, logic [31:0] d, bit drop_jtag = 0);
        @(posedge clk); #1;
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1;
        if (drop_jtag) jtag_active = 0;
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(logic [7:0] a, logic [31:0] exp, logic [31:0] mask, string tag);
        item_t it;
        it.exp = exp; it.mask = mask; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #1;
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(posedge clk); #1;
        penable = 1;
        @(posedge clk); #1;
        psel = 0; penable = 0;
    endtask

    // Read the count twice, 40 cycles apart, and expect a drop of 'drop'.
    task automatic count_delta(int drop, string tag);
        apb_read(8'h00, 0, 0, "probe");
        repeat (37) @(posedge clk);
        apb_read(8'h00, last_rd - drop, 32'h00FF_FFFF, tag);
    endtask

    task automatic hard_reset();
        @(posedge clk); #1; rst_n = 0;
        repeat (4) @(posedge clk);
        #1; rst_n = 1;
    endtask

    initial begin : watchdog
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        int p0;
        hard_reset();
        // R1 reset state
        apb_read(8'h00, 32'h0700_0000, 32'hFFFF_FFFF, "R1 ctrl");
        apb_read(8'h2C, 32'h0000_0200, 32'hFFFF_FFFF, "R1 tick");
        apb_read(8'h08, 32'h0, 32'hFFFF_FFFF, "R1 cause");
        apb_read(8'h0C, 32'h0, 32'hFFFF_FFFF, "R1 scratch0");
        chk("R1 pready", {31'b0, pready}, 32'h1);
        // R10 scratch words
        for (int i = 0; i < 8; i++) apb_write(8'(8'h0C + 4*i), 32'hA500_0000 + 32'(i * 32'h111));
        for (int i = 0; i < 8; i++)
            apb_read(8'(8'h0C + 4*i), 32'hA500_0000 + 32'(i * 32'h111), 32'hFFFF_FFFF, "R10 scratch");
        // R11 ignored writes and unmapped read
        apb_read(8'h30, 32'h0, 32'hFFFF_FFFF, "R11 unmapped");
        apb_write(8'h08, 32'h3);
        apb_read(8'h08, 32'h0, 32'hFFFF_FFFF, "R11 cause write ignored");
        // R8 divider stopped/running views
        apb_write(8'h2C, 32'h0000_0005);
        apb_read(8'h2C, 32'h0000_2805, 32'hFFFF_FFFF, "R8 stopped by enable");
        apb_write(8'h2C, 32'h0000_0200);
        apb_read(8'h2C, 32'h0000_0200, 32'hFFFF_FFFF, "R8 zero cycles not running");
        apb_write(8'h2C, 32'h0000_0205);
        apb_read(8'h2C, 32'h0000_0605, 32'h0000_07FF, "R8 running flag");
        // R2 load, R11 read-only count field
        apb_write(8'h04, 32'd1000);
        apb_read(8'h00, 32'h0700_0000 | 32'd1000, 32'hFFFF_FFFF, "R2 load");
        apb_read(8'h04, 32'h0, 32'hFFFF_FFFF, "R2 load reads zero");
        apb_write(8'h00, 32'h07FF_FFFF);
        apb_read(8'h00, 32'h0700_0000 | 32'd1000, 32'hFFFF_FFFF, "R11 count bits ignored");
        // R3/R8 decrement rate: 4-cycle ticks, 40 cycles -> 10 ticks -> -20
        apb_write(8'h2C, 32'h0000_0204);
        apb_write(8'h00, 32'h4700_0000);
        count_delta(20, "R3 R8 step two per tick");
        // R4 pausing
        jtag_active = 1;
        count_delta(0, "R4 jtag pause holds");
        apb_write(8'h00, 32'h4600_0000);
        count_delta(20, "R4 jtag ignored when pause bit clear");
        core0_halted = 1;
        count_delta(0, "R4 core0 pause holds");
        core0_halted = 0; jtag_active = 0;
        apb_write(8'h00, 32'h0700_0000);
        count_delta(0, "R4 disabled holds");
        // R6 forced trigger while disabled
        p0 = pulses;
        apb_write(8'h00, 32'h8700_0000);
        repeat (3) @(posedge clk);
        chk("R6 one pulse", 32'(pulses), 32'(p0 + 1));
        apb_read(8'h08, 32'h2, 32'hFFFF_FFFF, "R6 cause forced");
        apb_read(8'h00, 32'h0700_0000, 32'hFF00_0000, "R6 trigger reads zero, enable clear");
        // R3 saturation + R5 timeout
        apb_write(8'h2C, 32'h0000_0201);
        apb_write(8'h04, 32'd3);
        p0 = pulses;
        apb_write(8'h00, 32'h4700_0000);
        repeat (10) @(posedge clk);
        chk("R5 one timeout pulse", 32'(pulses), 32'(p0 + 1));
        apb_read(8'h08, 32'h1, 32'hFFFF_FFFF, "R5 cause timeout");
        apb_read(8'h00, 32'h0700_0000, 32'hFFFF_FFFF, "R3 R5 saturated at zero, enable clear");
        // R7 trigger and timeout on the same edge
        jtag_active = 1;
        apb_write(8'h04, 32'd0);
        p0 = pulses;
        apb_write(8'h00, 32'h4700_0000);
        repeat (5) @(posedge clk);
        chk("R7 no fire while paused", 32'(pulses), 32'(p0));
        apb_write(8'h00, 32'hC700_0000, 1);
        repeat (5) @(posedge clk);
        chk("R7 single pulse on collision", 32'(pulses), 32'(p0 + 1));
        apb_read(8'h08, 32'h2, 32'hFFFF_FFFF, "R7 forced wins");
        // R9 soft reset
        apb_write(8'h04, 32'd500);
        apb_write(8'h2C, 32'h0000_0207);
        apb_write(8'h00, 32'h4700_0000);
        @(posedge clk); #1; soft_rst = 1;
        @(posedge clk); #1; soft_rst = 0;
        apb_read(8'h00, 32'h0700_0000, 32'hFFFF_FFFF, "R9 ctrl cleared");
        apb_read(8'h2C, 32'h0000_0200, 32'hFFFF_FFFF, "R9 tick cleared");
        apb_read(8'h08, 32'h2, 32'hFFFF_FFFF, "R9 cause kept");
        apb_read(8'h18, 32'hA500_0333, 32'hFFFF_FFFF, "R9 scratch kept");
        // R1 hardware reset clears cause and scratch
        hard_reset();
        apb_read(8'h08, 32'h0, 32'hFFFF_FFFF, "R1 cause cleared by hard reset");
        apb_read(8'h18, 32'h0, 32'hFFFF_FFFF, "R1 scratch cleared by hard reset");
        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule